// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

This block turns a vector of wired interrupt inputs into posted message writes, one message for each interrupt event. Every input line has its own redirection entry. The entry sets whether the line is masked, whether it is active low or active high, and whether it is edge or level triggered. It also holds the 8-bit message data value and a 16-bit target made of a destination identifier and an extended identifier. When a line fires, the block presents the entry's target on `msg_addr` and its data on `msg_data`. It holds that message until the receiver accepts it with `msg_ready`.

Software reaches the table only through an indirect pair of registers. It writes an internal index to the select register at byte offset 0x00. Window accesses at offset 0x10 then read or write the internal register that the index names. A write to offset 0x40 is an end-of-interrupt (EOI) notice. Its low byte is compared with the message data of every level-triggered entry. An entry that matches leaves service, and it fires again if its line is still active and unmasked. Edge-triggered lines need no EOI.

Top module: `irq_msg_redirect`

## Requirements
- R1: After reset, every entry reads as masked (low word 0x0001_0000), the select register reads 0, and `msg_valid` is low.
- R2: A write at offset 0x00 sets the select index, and a read at offset 0x00 returns it. A read returns its data on `reg_rdata` with `reg_rvalid` high in the cycle after `reg_rd_en`. A window read after a window write returns the written value.
- R3: Internal index 0x01 is read-only. It reads as VERSION in bits 7:0 and NUM_LINES-1 in bits 23:16, with zeros elsewhere. Window writes to it are ignored.
- R4: Entry n keeps its low word at index 0x10+2n and its high word at index 0x11+2n. In the low word, bit 16 is mask, bit 15 selects level triggering, bit 13 selects active-low polarity, bits 7:0 are the message data, and every other bit reads as 0. In the high word, bits 31:24 are the destination identifier and bits 23:16 are the extended identifier. Bits 15:0 read as 0.
- R5: A window access to an index with no register behind it reads 0 and ignores writes. A read at offset 0x40 returns 0.
- R6: An unmasked edge-triggered line sends exactly one message for each inactive-to-active transition. The message has `msg_data` equal to the entry data and `msg_addr` equal to {destination, extended}. `msg_valid` rises on the second rising clock edge after the input changes, provided the output is idle.
- R7: With the active-low bit set, a line counts as active while its input is 0.
- R8: An unmasked level-triggered line that is active sends one message and then stays in service. It sends no further message until it receives an EOI write whose bits 7:0 equal its message data. After that EOI it fires again if it is still active, and stays silent if it is not.
- R9: An EOI write whose data matches no level-triggered entry has no effect on any line.
- R10: A masked line sends nothing. Edges that occur while a line is masked are lost. A level-triggered line that is active when it is unmasked sends a message.
- R11: When several lines are ready at once, the lowest-numbered entry is sent first. Only one message is presented at a time.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset: 0x00 select, 0x10 window, 0x40 EOI |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | High in the cycle that `reg_rdata` carries a read result |
| irq_in | input | NUM_LINES | Wired interrupt inputs |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 16 | Message target {destination, extended} |
| msg_data | output | 8 | Message data |

## Verification
The checker watches a set of properties on every cycle. It confirms that a read strobe always produces a read response one cycle later. It confirms that a waiting message stays frozen until it is accepted. It also confirms that at most one line is granted in any cycle, that the grant always goes to the lowest requesting line, that a grant is issued only into an idle output, and that a grant always produces a message.

Other behaviours can be shown only by the bench's scenarios, because they depend on the history of the table and of the inputs:
- whether the register layout and reserved bits are correct,
- whether the right line fires after polarity is applied,
- whether a level line stays silent until a matching EOI arrives,
- whether an EOI that matches nothing has no effect,
- whether edges that occur while a line is masked are lost.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  // host byte offsets
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;

  // internal indices
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_TAB = 8'h10;

  // low word bit positions
  localparam int B_MASK  = 16;
  localparam int B_LEVEL = 15;
  localparam int B_POL   = 13;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic       pol_low;
    logic [7:0] data;
    logic [7:0] dest;
    logic [7:0] ext;
  } entry_t;

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NUM_LINES = 8,
  parameter logic [7:0] VERSION   = 8'h21
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [7:0]                  addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output logic                        rvalid,
  output entry_t [NUM_LINES-1:0]      ent_tab,
  output logic                        eoi_hit,
  output logic [7:0]                  eoi_data
);

  localparam int         IDX_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [8:0] TAB_END = 9'(IDX_TAB) + 9'(2 * NUM_LINES);

  logic [7:0]       sel_q;
  logic [7:0]       sel_off;
  logic             in_tab;
  logic             sel_hi;
  logic [IDX_W-1:0] ent_idx;
  logic             win_wr;
  logic [31:0]      win_word;
  logic [31:0]      rd_word;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[14], wdata[12:8]};

  assign sel_off = sel_q - IDX_TAB;
  assign in_tab  = (sel_q >= IDX_TAB) && ({1'b0, sel_q} < TAB_END);
  assign sel_hi  = sel_off[0];
  assign ent_idx = sel_off[IDX_W:1];
  assign win_wr  = wr_en && (addr == OFS_WIN) && in_tab;

  assign eoi_hit  = wr_en && (addr == OFS_EOI);
  assign eoi_data = wdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_en && addr == OFS_SEL) begin
      sel_q <= wdata[7:0];
    end
  end

  // one storage slot per entry
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_ent
    entry_t ent_q;
    logic   wr_lo;
    logic   wr_hi;

    assign wr_lo = win_wr && (ent_idx == IDX_W'(g)) && !sel_hi;
    assign wr_hi = win_wr && (ent_idx == IDX_W'(g)) && sel_hi;

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= '{mask: 1'b1, default: '0};
      end else begin
        if (wr_lo) begin
          ent_q.mask    <= wdata[B_MASK];
          ent_q.level   <= wdata[B_LEVEL];
          ent_q.pol_low <= wdata[B_POL];
          ent_q.data    <= wdata[7:0];
        end
        if (wr_hi) begin
          ent_q.dest <= wdata[31:24];
          ent_q.ext  <= wdata[23:16];
        end
      end
    end

    assign ent_tab[g] = ent_q;
  end

  always_comb begin
    win_word = '0;
    if (sel_q == IDX_VER) begin
      win_word = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};
    end else if (in_tab) begin
      if (sel_hi) begin
        win_word = {ent_tab[ent_idx].dest, ent_tab[ent_idx].ext, 16'h0000};
      end else begin
        win_word = '0;
        win_word[B_MASK]  = ent_tab[ent_idx].mask;
        win_word[B_LEVEL] = ent_tab[ent_idx].level;
        win_word[B_POL]   = ent_tab[ent_idx].pol_low;
        win_word[7:0]     = ent_tab[ent_idx].data;
      end
    end
  end

  always_comb begin
    case (addr)
      OFS_SEL: rd_word = {24'h0, sel_q};
      OFS_WIN: rd_word = win_word;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

endmodule

// File: rtl/irq_redir_line.sv
module irq_redir_line (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  input  logic       ent_mask,
  input  logic       ent_level,
  input  logic       ent_pol,
  input  logic [7:0] ent_data,
  input  logic       grant,
  input  logic       eoi_hit,
  input  logic [7:0] eoi_data,
  output logic       req
);

  logic act;
  logic act_q;
  logic pend_q;
  logic insvc_q;
  logic set_edge;
  logic set_level;
  logic eoi_match;

  assign act       = irq ^ ent_pol;
  assign set_edge  = !ent_level && !ent_mask && act && !act_q;
  assign set_level = ent_level && !ent_mask && act && !insvc_q && !pend_q;
  assign eoi_match = eoi_hit && ent_level && (eoi_data == ent_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      act_q  <= act;
      pend_q <= (pend_q && !grant) || set_edge || set_level;
      if (grant)          insvc_q <= ent_level;
      else if (eoi_match) insvc_q <= 1'b0;
    end
  end

  assign req = pend_q && !ent_mask;

endmodule

// File: rtl/irq_redir_out.sv
module irq_redir_out #(
  parameter int NUM_LINES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        req,
  input  logic [NUM_LINES-1:0][23:0]  msg_tab,
  input  logic                        msg_ready,
  output logic [NUM_LINES-1:0]        grant,
  output logic                        msg_valid,
  output logic [15:0]                 msg_addr,
  output logic [7:0]                  msg_data
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic             found;
  logic [IDX_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  assign grant = (found && !msg_valid) ? (NUM_LINES'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
      msg_addr  <= '0;
    end else if (found && !msg_valid) begin
      msg_valid <= 1'b1;
      msg_data  <= msg_tab[pick][23:16];
      msg_addr  <= msg_tab[pick][15:0];
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_msg_redirect.sv
module irq_msg_redirect
  import irq_redir_pkg::*;
#(
  parameter int         NUM_LINES = 8,
  parameter logic [7:0] VERSION   = 8'h21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 reg_rvalid,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [15:0]          msg_addr,
  output logic [7:0]           msg_data
);

  entry_t [NUM_LINES-1:0]       ent_tab;
  logic [NUM_LINES-1:0][23:0]   msg_tab;
  logic [NUM_LINES-1:0]         line_req;
  logic [NUM_LINES-1:0]         grant;
  logic                         eoi_hit;
  logic [7:0]                   eoi_data;

  irq_redir_regs #(
    .NUM_LINES (NUM_LINES),
    .VERSION   (VERSION)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .rvalid   (reg_rvalid),
    .ent_tab  (ent_tab),
    .eoi_hit  (eoi_hit),
    .eoi_data (eoi_data)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign msg_tab[g] = {ent_tab[g].data, ent_tab[g].dest, ent_tab[g].ext};

    irq_redir_line u_line (
      .clk       (clk),
      .rst       (rst),
      .irq       (irq_in[g]),
      .ent_mask  (ent_tab[g].mask),
      .ent_level (ent_tab[g].level),
      .ent_pol   (ent_tab[g].pol_low),
      .ent_data  (ent_tab[g].data),
      .grant     (grant[g]),
      .eoi_hit   (eoi_hit),
      .eoi_data  (eoi_data),
      .req       (line_req[g])
    );
  end

  irq_redir_out #(
    .NUM_LINES (NUM_LINES)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .req       (line_req),
    .msg_tab   (msg_tab),
    .msg_ready (msg_ready),
    .grant     (grant),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_rd_en,
  input logic                 reg_rvalid,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [15:0]          msg_addr,
  input logic [7:0]           msg_data,
  input logic [NUM_LINES-1:0] req,
  input logic [NUM_LINES-1:0] grant
);

  a_r2_read_response: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> reg_rvalid);

  a_r12_hold_message: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_addr)));

  a_r11_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r11_lowest_first: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (((grant & req) != '0) && (((grant - 1'b1) & req) == '0)));

  a_r11_grant_when_idle: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> !msg_valid);

  a_r6_grant_loads: assert property (@(posedge clk) disable iff (rst)
    (|grant) |=> msg_valid);

endmodule

bind irq_msg_redirect irq_redir_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rd_en  (reg_rd_en),
  .reg_rvalid (reg_rvalid),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data),
  .req        (line_req),
  .grant      (grant)
);

// File: tb/sim_irq_msg_redirect.sv
module sim_irq_msg_redirect;

  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [NL-1:0] irq_in = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [15:0] msg_addr;
  logic [7:0]  msg_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_msg_redirect #(.NUM_LINES(NL), .VERSION(8'h21)) u0 (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // row: index, write data, expected readback
  localparam logic [71:0] VEC [9] = '{
    {8'h10, 32'hFFFF_FFFF, 32'h0001_A0FF},
    {8'h11, 32'hFFFF_FFFF, 32'hFFFF_0000},
    {8'h01, 32'h0000_1234, 32'h0007_0021},
    {8'h02, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h1F, 32'hAB12_3456, 32'hAB12_0000},
    {8'h1E, 32'h0001_0055, 32'h0001_0055},
    {8'h10, 32'h0001_0000, 32'h0001_0000},
    {8'h11, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    wr(8'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    rd(8'h10, d);
  endtask

  task automatic accept(input string req, input logic [7:0] d, input logic [15:0] a);
    check(req, {31'h0, msg_valid}, 32'h1);
    check(req, {24'h0, msg_data}, {24'h0, d});
    check(req, {16'h0, msg_addr}, {16'h0, a});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic idle(input string req, input int n);
    repeat (n) @(negedge clk);
    check(req, {31'h0, msg_valid}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", {31'h0, msg_valid}, 32'h0);
    rd(8'h00, r);      check("R1", r, 32'h0);
    win_rd(8'h12, r);  check("R1", r, 32'h0001_0000);
    win_rd(8'h1E, r);  check("R1", r, 32'h0001_0000);

    // table walk: R2 read-after-write, R3 version, R4 layout, R5 holes
    for (int i = 0; i < 9; i++) begin
      logic [7:0] idx;
      idx = VEC[i][71:64];
      win_wr(idx, VEC[i][63:32]);
      win_rd(idx, r);
      if (idx == 8'h01)                       check("R3", r, VEC[i][31:0]);
      else if (idx >= 8'h10 && idx < 8'h20)   check("R4 R2", r, VEC[i][31:0]);
      else                                    check("R5", r, VEC[i][31:0]);
    end

    // R2 select readback, R5 EOI offset reads zero
    wr(8'h00, 32'h0000_001F);
    rd(8'h00, r);  check("R2", r, 32'h1F);
    check("R2", {31'h0, reg_rvalid}, 32'h1);
    rd(8'h40, r);  check("R5", r, 32'h0);

    // R6 edge line 0, R12 hold
    win_wr(8'h11, 32'h5A3C_0000);
    win_wr(8'h10, 32'h0000_0041);
    irq_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R6", {31'h0, msg_valid}, 32'h1);
    msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", {31'h0, msg_valid}, 32'h1);
    check("R12", {24'h0, msg_data}, 32'h41);
    accept("R6", 8'h41, 16'h5A3C);
    idle("R6", 5);
    irq_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    irq_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    accept("R6", 8'h41, 16'h5A3C);

    // R7 active-low edge line 1, configured while masked
    win_wr(8'h12, 32'h0001_2042);
    win_wr(8'h12, 32'h0000_2042);
    idle("R7", 3);
    irq_in[1] = 1'b1;
    idle("R7", 3);
    irq_in[1] = 1'b0;
    repeat (2) @(negedge clk);
    accept("R7", 8'h42, 16'h0000);

    // R8 / R9 level line 2
    win_wr(8'h15, 32'h0100_0000);
    win_wr(8'h14, 32'h0000_8043);
    irq_in[2] = 1'b1;
    repeat (2) @(negedge clk);
    accept("R8", 8'h43, 16'h0100);
    idle("R8", 5);
    wr(8'h40, 32'h0000_0044);
    idle("R9", 4);
    wr(8'h40, 32'h0000_0043);
    repeat (2) @(negedge clk);
    accept("R8", 8'h43, 16'h0100);
    irq_in[2] = 1'b0;
    wr(8'h40, 32'h0000_0043);
    idle("R8", 4);

    // R10 mask: lost edge on line 3, level line 4 fires on unmask
    win_wr(8'h16, 32'h0001_0044);
    irq_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    irq_in[3] = 1'b0;
    idle("R10", 3);
    win_wr(8'h18, 32'h0001_8045);
    irq_in[4] = 1'b1;
    idle("R10", 3);
    win_wr(8'h18, 32'h0000_8045);
    repeat (2) @(negedge clk);
    accept("R10", 8'h45, 16'h0000);
    irq_in[4] = 1'b0;
    wr(8'h40, 32'h0000_0045);

    // R11 priority between lines 5 and 6
    win_wr(8'h1A, 32'h0000_0046);
    win_wr(8'h1C, 32'h0000_0047);
    irq_in[6] = 1'b1;
    irq_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    accept("R11", 8'h46, 16'h0000);
    check("R11", {31'h0, msg_valid}, 32'h0);
    @(negedge clk);
    accept("R11", 8'h47, 16'h0000);
    idle("R11", 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule